// File: doc/BRIEF.md
# PFC Output Fault Protection Supervisor

This block merges the output-side protections of a boost power-factor-correction controller into a single gate-enable decision. On every sample strobe it takes five digitised quantities: the feedback-pin current, the line-sense current, the reference current, the link voltage and the rectified line peak. From these it updates three latched fault flags.

The overvoltage check trips on the strobe in which the feedback current exceeds the reference by more than five percent. It releases only after the link voltage has fallen below a programmable level minus a hysteresis band. The loop-integrity check covers an output sense path that has failed open or shorted. It trips when the measured output falls below the measured line. It releases only when the output again meets or exceeds the line and the link voltage has climbed above the line peak. A third flag marks a lost line-sense current, which drops to zero when the input sense resistor fails.

Every check acts on the strobe itself, with no qualification delay. The expected latency is therefore set entirely by the sample rate. Gate switching stays off after reset until the first strobe has been taken.

Top module: `pfc_out_sup`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe is accepted, `gate_en` is 0 and all three fault flags are 0.
- R2: On a strobe with 20·`fb_cur` > 21·`ref_cur`, `ovp_flt` is 1 from the next cycle. A feedback current of exactly 105 % of the reference (20·fb = 21·ref) does not trip.
- R3: A set `ovp_flt` clears only on a strobe with `link_v` < OVP_LVL − OVP_HYST and no trip condition. With `link_v` equal to that level, the flag stays set.
- R4: On a strobe with `fb_cur` < `line_cur`, `loop_flt` is 1 from the next cycle.
- R5: A set `loop_flt` clears only on a strobe with `fb_cur` ≥ `line_cur` and `link_v` > `line_pk`. With `link_v` equal to `line_pk`, the flag stays set.
- R6: On a strobe with `line_cur` = 0, `line_lost` is 1 from the next cycle. It clears on the first strobe with `line_cur` ≠ 0.
- R7: When a trip condition and its release condition hold on the same strobe, the flag is set.
- R8: In cycles without a strobe, all inputs other than reset are ignored, and the flags and `gate_en` keep their values.
- R9: Once a strobe has been taken, `gate_en` is 1 exactly when all three flags are 0. The flags and `gate_en` reflect a strobe in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; inputs are evaluated on edges where it is 1 |
| fb_cur | input | W | Feedback-pin current code (measured output) |
| line_cur | input | W | Line-sense current code (measured line) |
| ref_cur | input | W | Reference current code |
| link_v | input | W | Link voltage code |
| line_pk | input | W | Rectified line peak code |
| gate_en | output | 1 | Gate-drive switching permitted |
| ovp_flt | output | 1 | Overvoltage fault latched |
| loop_flt | output | 1 | Open/short output loop fault latched |
| line_lost | output | 1 | Line-sense current lost |

## Verification
The properties assume that the input codes are stable and meaningful only on strobe edges. They also assume that OVP_HYST does not exceed OVP_LVL, so the release level does not wrap. The stimulus holds its codes from one falling edge to the next. It drives deliberately hostile values in cycles without a strobe, which exercises the hold behaviour. Directed vectors sit exactly on each comparison boundary: exactly 105 %, the release level itself, and a link equal to the peak. A constrained random sweep then covers all three detectors together, with values clustered around those thresholds.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

  typedef enum int unsigned {
    FLT_OVP  = 0,
    FLT_LOOP = 1,
    FLT_LINE = 2
  } flt_idx_e;

  localparam int unsigned NUM_FLT = 3;

  // Number of extra bits needed to hold a code times 21
  localparam int unsigned SCALE_BITS = 5;

endpackage

// File: rtl/pfc_ovp_cmp.sv
module pfc_ovp_cmp #(
  parameter int unsigned W        = 12,
  parameter int unsigned OVP_LVL  = 3000,
  parameter int unsigned OVP_HYST = 100
) (
  input  logic [W-1:0] fb_cur,
  input  logic [W-1:0] ref_cur,
  input  logic [W-1:0] link_v,
  output logic         trip,
  output logic         release_ok
);
  import pfc_sup_pkg::*;

  localparam int unsigned PW      = W + SCALE_BITS;
  localparam logic [W-1:0] REL_LVL = W'(OVP_LVL - OVP_HYST);

  logic [PW-1:0] fb_ext;
  logic [PW-1:0] ref_ext;
  logic [PW-1:0] fb_x20;
  logic [PW-1:0] ref_x21;

  always_comb begin
    fb_ext  = {{SCALE_BITS{1'b0}}, fb_cur};
    ref_ext = {{SCALE_BITS{1'b0}}, ref_cur};
    // shift-and-add scaling keeps the compare free of division
    fb_x20  = (fb_ext << 4) + (fb_ext << 2);
    ref_x21 = (ref_ext << 4) + (ref_ext << 2) + ref_ext;
  end

  assign trip       = (fb_x20 > ref_x21);
  assign release_ok = (link_v < REL_LVL);

endmodule

// File: rtl/pfc_loop_cmp.sv
module pfc_loop_cmp #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] fb_cur,
  input  logic [W-1:0] line_cur,
  input  logic [W-1:0] link_v,
  input  logic [W-1:0] line_pk,
  output logic         loop_trip,
  output logic         loop_rec,
  output logic         line_trip,
  output logic         line_rec
);

  logic out_below_line;
  logic link_above_pk;

  always_comb begin
    out_below_line = (fb_cur < line_cur);
    link_above_pk  = (link_v > line_pk);
    loop_trip      = out_below_line;
    loop_rec       = !out_below_line && link_above_pk;
    line_trip      = (line_cur == '0);
    line_rec       = (line_cur != '0);
  end

endmodule

// File: rtl/pfc_fault_latch.sv
module pfc_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic trip,
  input  logic clr,
  output logic flag
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (trip) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/pfc_gate_ctl.sv
module pfc_gate_ctl #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [N-1:0] flags,
  output logic         gate_en
);

  logic primed_q;
  logic primed_d;

  always_comb begin
    primed_d = primed_q | smp_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
    end else if (smp_vld) begin
      primed_q <= primed_d;
    end
  end

  assign gate_en = primed_q && (flags == '0);

endmodule

// File: rtl/pfc_out_sup.sv
module pfc_out_sup #(
  parameter int unsigned W        = 12,
  parameter int unsigned OVP_LVL  = 3000,
  parameter int unsigned OVP_HYST = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] fb_cur,
  input  logic [W-1:0] line_cur,
  input  logic [W-1:0] ref_cur,
  input  logic [W-1:0] link_v,
  input  logic [W-1:0] line_pk,
  output logic         gate_en,
  output logic         ovp_flt,
  output logic         loop_flt,
  output logic         line_lost
);
  import pfc_sup_pkg::*;

  logic [NUM_FLT-1:0] trip_v;
  logic [NUM_FLT-1:0] clr_v;
  logic [NUM_FLT-1:0] flag_v;

  pfc_ovp_cmp #(
    .W        (W),
    .OVP_LVL  (OVP_LVL),
    .OVP_HYST (OVP_HYST)
  ) i_ovp (
    .fb_cur     (fb_cur),
    .ref_cur    (ref_cur),
    .link_v     (link_v),
    .trip       (trip_v[FLT_OVP]),
    .release_ok (clr_v[FLT_OVP])
  );

  pfc_loop_cmp #(
    .W (W)
  ) i_loop (
    .fb_cur    (fb_cur),
    .line_cur  (line_cur),
    .link_v    (link_v),
    .line_pk   (line_pk),
    .loop_trip (trip_v[FLT_LOOP]),
    .loop_rec  (clr_v[FLT_LOOP]),
    .line_trip (trip_v[FLT_LINE]),
    .line_rec  (clr_v[FLT_LINE])
  );

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    pfc_fault_latch i_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (smp_vld),
      .trip  (trip_v[g]),
      .clr   (clr_v[g]),
      .flag  (flag_v[g])
    );
  end

  pfc_gate_ctl #(
    .N (NUM_FLT)
  ) i_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .flags   (flag_v),
    .gate_en (gate_en)
  );

  assign ovp_flt   = flag_v[FLT_OVP];
  assign loop_flt  = flag_v[FLT_LOOP];
  assign line_lost = flag_v[FLT_LINE];

endmodule

// File: rtl/pfc_out_sup_chk.sv
module pfc_out_sup_chk #(
  parameter int unsigned W        = 12,
  parameter int unsigned OVP_LVL  = 3000,
  parameter int unsigned OVP_HYST = 100
) (
  input logic         clk,
  input logic         rst_n,
  input logic         smp_vld,
  input logic [W-1:0] fb_cur,
  input logic [W-1:0] line_cur,
  input logic [W-1:0] ref_cur,
  input logic [W-1:0] link_v,
  input logic [W-1:0] line_pk,
  input logic         gate_en,
  input logic         ovp_flt,
  input logic         loop_flt,
  input logic         line_lost
);

  logic ov_hi;
  logic ov_rel;
  assign ov_hi  = (32'(fb_cur) * 32'd20) > (32'(ref_cur) * 32'd21);
  assign ov_rel = 32'(link_v) < (OVP_LVL - OVP_HYST);

  AST_OVP_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && ov_hi |=> ovp_flt); // R2

  AST_OVP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && ovp_flt && !ov_rel |=> ovp_flt); // R3

  AST_LOOP_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (fb_cur < line_cur) |=> loop_flt); // R4

  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && loop_flt && !((fb_cur >= line_cur) && (link_v > line_pk)) |=> loop_flt); // R5

  AST_LINE_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (line_cur == '0) |=> line_lost); // R6

  AST_TRIP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && ov_hi && ov_rel |=> ovp_flt); // R7

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable({ovp_flt, loop_flt, line_lost, gate_en})); // R8

  AST_GATE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> !(ovp_flt || loop_flt || line_lost)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> !gate_en && !ovp_flt && !loop_flt && !line_lost); // R1

endmodule

bind pfc_out_sup pfc_out_sup_chk #(
  .W        (W),
  .OVP_LVL  (OVP_LVL),
  .OVP_HYST (OVP_HYST)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .fb_cur    (fb_cur),
  .line_cur  (line_cur),
  .ref_cur   (ref_cur),
  .link_v    (link_v),
  .line_pk   (line_pk),
  .gate_en   (gate_en),
  .ovp_flt   (ovp_flt),
  .loop_flt  (loop_flt),
  .line_lost (line_lost)
);

// File: tb/test_pfc_out_sup.sv
module test_pfc_out_sup;
  localparam int CLK_P = 10;
  localparam int W     = 12;
  localparam int LVL   = 3000;
  localparam int HYST  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [W-1:0] fb_cur = '0, line_cur = '0, ref_cur = '0, link_v = '0, line_pk = '0;
  logic gate_en, ovp_flt, loop_flt, line_lost;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  bit m_ovp, m_loop, m_line, m_primed;

  always #(CLK_P/2) clk = ~clk;

  pfc_out_sup #(.W(W), .OVP_LVL(LVL), .OVP_HYST(HYST)) i_pfc_out_sup (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .fb_cur(fb_cur), .line_cur(line_cur), .ref_cur(ref_cur),
    .link_v(link_v), .line_pk(line_pk),
    .gate_en(gate_en), .ovp_flt(ovp_flt), .loop_flt(loop_flt), .line_lost(line_lost)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovp = 0; m_loop = 0; m_line = 0; m_primed = 0;
    end else if (smp_vld) begin
      int fb, ln, rf, lk, pk;
      fb = fb_cur; ln = line_cur; rf = ref_cur; lk = link_v; pk = line_pk;
      m_primed = 1;
      if (20 * fb > 21 * rf) m_ovp = 1;
      else if (lk < LVL - HYST) m_ovp = 0;
      if (fb < ln) m_loop = 1;
      else if (fb >= ln && lk > pk) m_loop = 0;
      if (ln == 0) m_line = 1;
      else m_line = 0;
    end
  end

  task automatic compare();
    bit exp_gate;
    exp_gate = m_primed && !m_ovp && !m_loop && !m_line;
    vecs++;
    if ({gate_en, ovp_flt, loop_flt, line_lost} !== {exp_gate, m_ovp, m_loop, m_line}) begin
      errs++;
      $display("FAIL %s t=%0t gate/ovp/loop/line actual=%b%b%b%b expected=%b%b%b%b",
               tag, $time, gate_en, ovp_flt, loop_flt, line_lost,
               exp_gate, m_ovp, m_loop, m_line);
    end
  endtask

  task automatic apply(input bit v, input int fb, input int ln, input int rf,
                       input int lk, input int pk);
    @(negedge clk);
    compare();
    smp_vld = v; fb_cur = W'(fb); line_cur = W'(ln); ref_cur = W'(rf);
    link_v = W'(lk); line_pk = W'(pk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    // R1: reset state and no gate before first strobe
    tag = "R1";
    repeat (3) apply(0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) apply(0, 1000, 500, 1000, 2000, 1500);
    // R9: first healthy strobe enables the gate
    tag = "R9";
    apply(1, 1000, 500, 1000, 2000, 1500);
    apply(0, 1000, 500, 1000, 2000, 1500);
    // R8: hostile inputs without strobe are ignored
    tag = "R8";
    apply(0, 4000, 4000, 10, 10, 4000);
    apply(0, 10, 0, 10, 10, 4000);
    apply(0, 1000, 500, 1000, 2000, 1500);
    // R2: exactly 105 % does not trip, just above trips
    tag = "R2";
    apply(1, 1050, 500, 1000, 3000, 1500);
    apply(0, 1050, 500, 1000, 3000, 1500);
    apply(1, 1051, 500, 1000, 3000, 1500);
    apply(0, 1000, 500, 1000, 3000, 1500);
    // R3: release level holds, below it releases
    tag = "R3";
    apply(1, 1000, 500, 1000, 2900, 1500);
    apply(1, 1000, 500, 1000, 2899, 1500);
    apply(0, 1000, 500, 1000, 2899, 1500);
    // R7: trip and release together keep the fault
    tag = "R7";
    apply(1, 1100, 500, 1000, 100, 50);
    apply(1, 1100, 500, 1000, 100, 50);
    apply(1, 1000, 500, 1000, 100, 50);
    apply(0, 1000, 500, 1000, 2000, 1500);
    // R4: output below line trips
    tag = "R4";
    apply(1, 400, 500, 1000, 2000, 1500);
    apply(0, 400, 500, 1000, 2000, 1500);
    // R5: link equal to peak holds, above releases
    tag = "R5";
    apply(1, 500, 500, 1000, 1500, 1500);
    apply(1, 600, 500, 1000, 1000, 1500);
    apply(1, 500, 500, 1000, 1501, 1500);
    apply(0, 500, 500, 1000, 1501, 1500);
    // R6: lost line-sense current
    tag = "R6";
    apply(1, 1000, 0, 1000, 2000, 1500);
    apply(0, 1000, 0, 1000, 2000, 1500);
    apply(1, 1000, 10, 1000, 2000, 1500);
    apply(0, 1000, 10, 1000, 2000, 1500);
    // R9: random sweep clustered near thresholds
    tag = "R9";
    for (int i = 0; i < 2000; i++) begin
      int rf, fb, ln, lk, pk;
      rf = 900 + int'($urandom_range(0, 200));
      fb = rf + int'($urandom_range(0, 120)) - 60;
      ln = (($urandom_range(0, 15) == 0) ? 0 : fb + int'($urandom_range(0, 40)) - 30);
      if (ln < 0) ln = 0;
      pk = 1400 + int'($urandom_range(0, 200));
      lk = (($urandom_range(0, 1) == 1) ? pk + int'($urandom_range(0, 3)) - 1
                                        : 2850 + int'($urandom_range(0, 100)));
      apply(($urandom_range(0, 3) != 0), fb, ln, rf, lk, pk);
    end
    // R1: reset mid-run clears everything
    tag = "R1";
    apply(1, 400, 0, 10, 10, 4000);
    @(negedge clk); rst_n = 1'b0;
    apply(0, 400, 0, 10, 10, 4000);
    apply(1, 400, 0, 10, 10, 4000);
    @(negedge clk); rst_n = 1'b1; smp_vld = 1'b0;
    apply(0, 1000, 500, 1000, 2000, 1500);
    apply(0, 1000, 500, 1000, 2000, 1500);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule